// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two 18-bit ports, A and B, through two independent paths, A-to-B and B-to-A. Each path keeps one storage word that acts as a transparent latch or as a falling-edge register, depending on its controls. Each direction has four controls of its own: an active-low output enable, a latch enable, a path clock and an active-low clock enable. Together they give transparent, latched, clocked and clock-enabled operation on each path.

The block sits behind a pad ring. Each port is split into an input word (`*_i`), a driven word (`*_o`) and a drive enable (`*_oe_o`). A low drive enable means the pad is high-impedance. The path clocks, latch enables, clock enables and input data are asynchronous to the system clock `clk_i`. They are sampled through `SYNC_STAGES` flops and then acted on as one aligned snapshot. The output therefore follows its sampled input `SYNC_STAGES + 1` rising edges of `clk_i` after the input settles.

When the block drives a port, the path that reads that port takes the block's own driven word as its input, just as a real pad would. It does not take the pad input word.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both stored words are zero. With the output enables high, both drive enables are low.
- R2: When a path's latch enable is high, that path's stored word takes its input word. The value shows on the destination port `SYNC_STAGES + 1` system-clock edges (3 by default) after the input is applied.
- R3: When the latch enable is low and the path clock does not change, the stored word holds its value, whatever the input word does.
- R4: When the latch enable is low and the clock enable is low, a high-to-low change of the path clock loads the input word. A low-to-high change loads nothing.
- R5: When the clock enable is high and the latch enable is low, path-clock edges leave the stored word unchanged.
- R6: The output enable is active low. When it is low, the destination drive enable is 1 and the destination word is the stored word. When it is high, the drive enable is 0 and the port is high-impedance.
- R7: The B-to-A path behaves as R2–R6 describe, using its own four controls. No control of one path changes the other path's stored word.
- R8: While the B-to-A output enable is low, the A-to-B path reads the block's own A drive word in place of `a_i`. The same holds with the roles of A and B swapped.
- R9: Every word is `W` bits wide, 18 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Value seen on the A pads |
| a_o | output | W | Word driven onto A (B-to-A storage) |
| a_oe_o | output | 1 | A pad drive enable, 0 = high-impedance |
| b_i | input | W | Value seen on the B pads |
| b_o | output | W | Word driven onto B (A-to-B storage) |
| b_oe_o | output | 1 | B pad drive enable, 0 = high-impedance |
| oe_ab_ni | input | 1 | A-to-B output enable, active low |
| le_ab_i | input | 1 | A-to-B latch enable |
| clk_ab_i | input | 1 | A-to-B path clock |
| cken_ab_ni | input | 1 | A-to-B clock enable, active low |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |
| le_ba_i | input | 1 | B-to-A latch enable |
| clk_ba_i | input | 1 | B-to-A path clock |
| cken_ba_ni | input | 1 | B-to-A clock enable, active low |

## Verification
Directed steps first change the input under each latched or clocked setting, with the latch enable high, then low, and with the clock held high, falling, rising and gated. A value that moves when it should not therefore separates latch, register and gate faults. Distinct words such as alternating-bit, all-ones and sparse values show whether the A and B paths ever cross-load. A phase with both paths driving tells the loopback source apart from the pad input. A long random phase then toggles all eight controls at once, and a behavioural model compares every output on every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DATA_W      = 18;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic le;
    logic clk;
    logic cken_n;
  } ctl_t;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] data_o,
  output ctl_t         ctl_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign data_o = data_i;
      assign ctl_o  = ctl_i;
    end else begin : g_pipe
      logic [W-1:0] data_q [STAGES];
      ctl_t         ctl_q  [STAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) begin
            data_q[i] <= '0;
            ctl_q[i]  <= '0;
          end
        end else begin
          data_q[0] <= data_i;
          ctl_q[0]  <= ctl_i;
          for (int i = 1; i < STAGES; i++) begin
            data_q[i] <= data_q[i-1];
            ctl_q[i]  <= ctl_q[i-1];
          end
        end
      end

      assign data_o = data_q[STAGES-1];
      assign ctl_o  = ctl_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] q_o
);
  logic clk_prev_q;
  logic clk_fall;
  logic load;

  // merged latch / falling-edge register
  assign clk_fall = clk_prev_q & ~ctl_i.clk;
  assign load     = ctl_i.le | (clk_fall & ~ctl_i.cken_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q <= 1'b0;
      q_o        <= '0;
    end else begin
      clk_prev_q <= ctl_i.clk;
      if (load) q_o <= data_i;
    end
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         le_i,
  input  logic         pclk_i,
  input  logic         cken_ni,
  output logic [W-1:0] q_o,
  output logic [W-1:0] smp_data_o,
  output ctl_t         smp_ctl_o
);
  ctl_t ctl_raw;

  assign ctl_raw = '{le: le_i, clk: pclk_i, cken_n: cken_ni};

  xcvr_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .ctl_i  (ctl_raw),
    .data_o (smp_data_o),
    .ctl_o  (smp_ctl_o)
  );

  xcvr_cell #(.W(W)) u_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (smp_data_o),
    .ctl_i  (smp_ctl_o),
    .q_o    (q_o)
  );
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         oe_ab_ni,
  input  logic         le_ab_i,
  input  logic         clk_ab_i,
  input  logic         cken_ab_ni,
  input  logic         oe_ba_ni,
  input  logic         le_ba_i,
  input  logic         clk_ba_i,
  input  logic         cken_ba_ni
);
  logic [W-1:0] ab_src, ba_src;
  logic [W-1:0] ab_q, ba_q;
  logic [W-1:0] ab_smp_data, ba_smp_data;
  ctl_t         ab_smp_ctl, ba_smp_ctl;

  // a driven pad reads back its own drive word
  assign ab_src = oe_ba_ni ? a_i : ba_q;
  assign ba_src = oe_ab_ni ? b_i : ab_q;

  xcvr_path #(.W(W), .STAGES(STAGES)) u_ab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (ab_src),
    .le_i       (le_ab_i),
    .pclk_i     (clk_ab_i),
    .cken_ni    (cken_ab_ni),
    .q_o        (ab_q),
    .smp_data_o (ab_smp_data),
    .smp_ctl_o  (ab_smp_ctl)
  );

  xcvr_path #(.W(W), .STAGES(STAGES)) u_ba (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (ba_src),
    .le_i       (le_ba_i),
    .pclk_i     (clk_ba_i),
    .cken_ni    (cken_ba_ni),
    .q_o        (ba_q),
    .smp_data_o (ba_smp_data),
    .smp_ctl_o  (ba_smp_ctl)
  );

  assign b_o    = ab_q;
  assign b_oe_o = ~oe_ab_ni;
  assign a_o    = ba_q;
  assign a_oe_o = ~oe_ba_ni;
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic [W-1:0] ab_smp_data,
  input logic [W-1:0] ba_smp_data,
  input ctl_t         ab_smp_ctl,
  input ctl_t         ba_smp_ctl
);
  assert_ab_transparent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_smp_ctl.le |=> ab_q == $past(ab_smp_data));

  assert_ab_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_smp_ctl.le && $stable(ab_smp_ctl.clk)) |=> $stable(ab_q));

  assert_ab_fall_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_smp_ctl.le && !ab_smp_ctl.cken_n && $fell(ab_smp_ctl.clk)) |=> ab_q == $past(ab_smp_data));

  assert_ab_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_smp_ctl.le && ab_smp_ctl.cken_n) |=> $stable(ab_q));

  assert_ba_transparent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_smp_ctl.le |=> ba_q == $past(ba_smp_data));

  assert_ba_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_smp_ctl.le && $stable(ba_smp_ctl.clk)) |=> $stable(ba_q));

  assert_ba_fall_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_smp_ctl.le && !ba_smp_ctl.cken_n && $fell(ba_smp_ctl.clk)) |=> ba_q == $past(ba_smp_data));

  assert_ba_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_smp_ctl.le && ba_smp_ctl.cken_n) |=> $stable(ba_q));
endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ab_q        (ab_q),
  .ba_q        (ba_q),
  .ab_smp_data (ab_smp_data),
  .ba_smp_data (ba_smp_data),
  .ab_smp_ctl  (ab_smp_ctl),
  .ba_smp_ctl  (ba_smp_ctl)
);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
module bus_xcvr_test;
  localparam int W = 18;
  localparam int S = 2;

  typedef struct {
    logic [W-1:0] d;
    logic         le;
    logic         ck;
    logic         ce_n;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic oe_ab_n = 1'b1, le_ab = 1'b0, ck_ab = 1'b0, ce_ab_n = 1'b1;
  logic oe_ba_n = 1'b1, le_ba = 1'b0, ck_ba = 1'b0, ce_ba_n = 1'b1;
  wire  [W-1:0] a_o, b_o;
  wire          a_oe, b_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  logic  done = 1'b0;

  always #2 clk = ~clk;

  bus_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe),
    .oe_ab_ni(oe_ab_n), .le_ab_i(le_ab), .clk_ab_i(ck_ab), .cken_ab_ni(ce_ab_n),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .clk_ba_i(ck_ba), .cken_ba_ni(ce_ba_n)
  );

  // reference model
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic prv_ab = 1'b0, prv_ba = 1'b0;
  snap_t q_ab[$], q_ba[$];

  task automatic model_clear();
    snap_t z;
    z = '{d: '0, le: 1'b0, ck: 1'b0, ce_n: 1'b0};
    m_ab = '0; m_ba = '0; prv_ab = 1'b0; prv_ba = 1'b0;
    q_ab.delete(); q_ba.delete();
    for (int i = 0; i < S; i++) begin
      q_ab.push_back(z);
      q_ba.push_back(z);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      snap_t ca, cb;
      ca = '{d: (oe_ba_n ? a_i : m_ba), le: le_ab, ck: ck_ab, ce_n: ce_ab_n};
      cb = '{d: (oe_ab_n ? b_i : m_ab), le: le_ba, ck: ck_ba, ce_n: ce_ba_n};
      q_ab.push_back(ca);
      q_ba.push_back(cb);
      ca = q_ab.pop_front();
      cb = q_ba.pop_front();
      if (ca.le || (prv_ab && !ca.ck && !ca.ce_n)) m_ab = ca.d;
      if (cb.le || (prv_ba && !cb.ck && !cb.ce_n)) m_ba = cb.d;
      prv_ab = ca.ck;
      prv_ba = cb.ck;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check({tag, " b_o"}, b_o, m_ab);
      check({tag, " a_o"}, a_o, m_ba);
      check("R6 b_oe", W'(b_oe), W'(!oe_ab_n));
      check("R6 a_oe", W'(a_oe), W'(!oe_ba_n));
    end
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    model_clear();
    step(3);
    check("R1 b_o", b_o, '0);
    check("R1 a_o", a_o, '0);
    check("R1 b_oe", W'(b_oe), '0);
    rst_n = 1'b1;
    step(2);
    check("R1 a_oe", W'(a_oe), '0);

    // R2 transparent A->B
    tag = "R2";
    oe_ab_n = 1'b0; le_ab = 1'b1; a_i = 18'h2A5A5;
    step(4);
    check("R2 transparent", b_o, 18'h2A5A5);
    check("R6 b_oe low oe_n", W'(b_oe), W'(1));

    // R3 hold with steady clock
    tag = "R3";
    ck_ab = 1'b1; ce_ab_n = 1'b0; step(1);
    le_ab = 1'b0; step(1);
    a_i = 18'h15555;
    step(6);
    check("R3 hold", b_o, 18'h2A5A5);

    // R4 falling edge captures, rising does not
    tag = "R4";
    ck_ab = 1'b0; step(4);
    check("R4 fall capture", b_o, 18'h15555);
    a_i = 18'h3FFFF; step(1);
    ck_ab = 1'b1; step(4);
    check("R4 rise ignored", b_o, 18'h15555);
    ck_ab = 1'b0; step(4);
    check("R4 second fall", b_o, 18'h3FFFF);

    // R5 clock enable high blocks capture
    tag = "R5";
    ce_ab_n = 1'b1; a_i = 18'h00F0F; step(1);
    ck_ab = 1'b1; step(2);
    ck_ab = 1'b0; step(4);
    check("R5 gated", b_o, 18'h3FFFF);

    // R7 mirror path, A->B untouched
    tag = "R7";
    oe_ab_n = 1'b1; oe_ba_n = 1'b0; le_ba = 1'b1; b_i = 18'h12345;
    step(4);
    check("R7 ba transparent", a_o, 18'h12345);
    check("R7 ab unaffected", b_o, 18'h3FFFF);
    check("R6 b_oe off", W'(b_oe), '0);
    ck_ba = 1'b1; ce_ba_n = 1'b0; step(1);
    le_ba = 1'b0; b_i = 18'h0ABCD; step(5);
    check("R7 ba hold", a_o, 18'h12345);
    ck_ba = 1'b0; step(4);
    check("R7 ba fall capture", a_o, 18'h0ABCD);

    // R8 A->B reads own A drive word while A is driven
    tag = "R8";
    a_i = 18'h00001; le_ab = 1'b1; oe_ab_n = 1'b0;
    step(5);
    check("R8 loopback", b_o, 18'h0ABCD);
    oe_ba_n = 1'b1; step(5);
    check("R8 pad input", b_o, 18'h00001);

    // R9 full-width random traffic, both paths
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      a_i = W'($urandom); b_i = W'($urandom);
      oe_ab_n = 1'($urandom); le_ab = ($urandom % 4) == 0;
      ck_ab = 1'($urandom); ce_ab_n = 1'($urandom);
      oe_ba_n = 1'($urandom); le_ba = ($urandom % 4) == 0;
      ck_ba = 1'($urandom); ce_ba_n = 1'($urandom);
      step(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule